// File: doc/BRIEF.md
# Scrub Interval Read Scheduler

This block decides when a memory controller may launch a background scrub read. An internal interval counter advances once per clock while scrubbing is allowed. It is compared with a 12-bit interval taken from a fixed field of a 32-bit configuration word. Once the counter has reached the programmed interval, the block raises a scrub-read request. The request is held back while a scrub write-back is valid or a previous one is still pending. The whole mechanism is suppressed while scrubbing is disabled or the controller is in hardware self-refresh.

The request is combinational from the counter and the status inputs. The controller answers an asserted request with an acknowledge. An accepted request clears the counter, so the next interval is timed from zero. While the request waits for service, the counter saturates rather than wrapping, so an overdue scrub is never forgotten.

Top module: `scrub_read_sched`

## Requirements
- R1: On an active-low asynchronous reset the interval counter is zero, so with interval 1 and scrubbing enabled the request output stays low during reset and in the first cycle after it.
- R2: With scrubbing enabled and no blocker, the request rises in the cycle after the N-th rising clock edge following reset release, for a programmed interval of N. It is low after N-1 edges.
- R3: The request stays asserted while the counter is greater than or equal to the interval; equality is not required.
- R4: A cycle with the request high and the acknowledge high clears the counter to zero, and the next request comes N edges later.
- R5: An acknowledge while the request is low is ignored and does not clear the counter.
- R6: While scrub enable is low the request is low and the counter holds its value.
- R7: While self-refresh is high the request is low and the counter holds its value.
- R8: While the scrub-write-valid input is high the request is low.
- R9: While the scrub-write-pending input is high the request is low.
- R10: The counter saturates at its maximum (4095) and does not wrap, so with interval 4095 the request stays high after the interval is reached.
- R11: The interval is taken from bits [20:9] of the configuration word; all other bits have no effect.
- R12: With interval 0 and scrubbing enabled, the request is high from the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Configuration word holding the interval field |
| scrubEn | input | 1 | Data scrubbing enabled |
| selfRefresh | input | 1 | Controller is in hardware self-refresh |
| scrubWrValid | input | 1 | A scrub write-back is currently valid |
| scrubWrPending | input | 1 | A previous scrub write-back is still pending |
| scrubRdAck | input | 1 | Controller accepts the scrub read request |
| scrubRdEn | output | 1 | Scrub read request |

## Verification
The bench builds the block with its default parameters: a 12-bit counter and the interval field starting at bit 9 of a 32-bit word. With these values, the largest interval of 4095 can be reached in about four thousand cycles, so saturation at the top of the counter is exercised directly instead of through a narrowed copy. Short intervals (0, 3 and 5) give exact edge counts for the threshold, the clear on acknowledge and the hold while disabled. The field test fills every bit outside [20:9] with ones to show that those bits have no effect.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  // strobes from the gating control to the interval datapath
  typedef struct packed {
    logic clr;  // restart interval from zero
    logic inc;  // advance interval counter by one
  } cntStrobe_t;
endpackage

// File: rtl/scrub_interval_dp.sv
module scrub_interval_dp
  import scrub_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] intervalVal,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] intervalCnt,
  output logic             cntSat,
  output logic             reached
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (strobe.clr) begin
      intervalCnt <= '0;
    end else if (strobe.inc) begin
      intervalCnt <= intervalCnt + CNT_W'(1);
    end
  end

  assign cntSat  = (intervalCnt == CNT_MAX);
  assign reached = (intervalCnt >= intervalVal);
endmodule

// File: rtl/scrub_gate_ctl.sv
module scrub_gate_ctl
  import scrub_pkg::*;
(
  input  logic       scrubEn,
  input  logic       selfRefresh,
  input  logic       scrubWrValid,
  input  logic       scrubWrPending,
  input  logic       scrubRdAck,
  input  logic       reached,
  input  logic       cntSat,
  output cntStrobe_t strobe,
  output logic       scrubRdEn
);
  logic runOk;
  logic timeUp;

  // interval is only live when scrubbing is on and not in self-refresh
  assign runOk     = scrubEn & ~selfRefresh;
  assign timeUp    = reached & runOk;
  assign scrubRdEn = timeUp & ~(scrubWrValid | scrubWrPending);

  always_comb begin
    strobe.clr = scrubRdEn & scrubRdAck;
    strobe.inc = runOk & ~cntSat & ~strobe.clr;
  end
endmodule

// File: rtl/scrub_read_sched.sv
module scrub_read_sched
  import scrub_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int CFG_W     = 32,
  parameter int FIELD_LSB = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             scrubEn,
  input  logic             selfRefresh,
  input  logic             scrubWrValid,
  input  logic             scrubWrPending,
  input  logic             scrubRdAck,
  output logic             scrubRdEn
);
  logic [CNT_W-1:0] intervalVal;
  logic [CNT_W-1:0] intervalCnt;
  logic             cntSat;
  logic             reached;
  cntStrobe_t       strobe;

  assign intervalVal = CNT_W'(cfgWord >> FIELD_LSB);

  scrub_interval_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .intervalVal(intervalVal),
    .strobe     (strobe),
    .intervalCnt(intervalCnt),
    .cntSat     (cntSat),
    .reached    (reached)
  );

  scrub_gate_ctl u_ctl (
    .scrubEn       (scrubEn),
    .selfRefresh   (selfRefresh),
    .scrubWrValid  (scrubWrValid),
    .scrubWrPending(scrubWrPending),
    .scrubRdAck    (scrubRdAck),
    .reached       (reached),
    .cntSat        (cntSat),
    .strobe        (strobe),
    .scrubRdEn     (scrubRdEn)
  );
endmodule

// File: rtl/scrub_read_sched_chk.sv
module scrub_read_sched_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             scrubEn,
  input logic             selfRefresh,
  input logic             scrubWrValid,
  input logic             scrubWrPending,
  input logic             scrubRdAck,
  input logic             scrubRdEn,
  input logic [CNT_W-1:0] intervalCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_clear_on_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (scrubRdEn && scrubRdAck) |=> (intervalCnt == '0));

  p_idle_ack_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!scrubRdEn && scrubRdAck && scrubEn && !selfRefresh && intervalCnt != CNT_MAX)
      |=> (intervalCnt == $past(intervalCnt) + CNT_W'(1)));

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !scrubEn |-> !scrubRdEn);

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !scrubEn |=> $stable(intervalCnt));

  p_selfref_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |-> !scrubRdEn);

  p_selfref_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |=> $stable(intervalCnt));

  p_wr_valid_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    scrubWrValid |-> !scrubRdEn);

  p_wr_pending_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    scrubWrPending |-> !scrubRdEn);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intervalCnt == CNT_MAX && !(scrubRdEn && scrubRdAck)) |=> (intervalCnt == CNT_MAX));
endmodule

bind scrub_read_sched scrub_read_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .scrubEn       (scrubEn),
  .selfRefresh   (selfRefresh),
  .scrubWrValid  (scrubWrValid),
  .scrubWrPending(scrubWrPending),
  .scrubRdAck    (scrubRdAck),
  .scrubRdEn     (scrubRdEn),
  .intervalCnt   (intervalCnt)
);

// File: tb/sim_scrub_read_sched.sv
`timescale 1ns/1ps
module sim_scrub_read_sched;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] cfgWord;
  logic        scrubEn, selfRefresh, scrubWrValid, scrubWrPending, scrubRdAck;
  logic        scrubRdEn;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  scrub_read_sched u0 (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .scrubEn(scrubEn),
    .selfRefresh(selfRefresh), .scrubWrValid(scrubWrValid),
    .scrubWrPending(scrubWrPending), .scrubRdAck(scrubRdAck),
    .scrubRdEn(scrubRdEn)
  );

  function automatic logic [31:0] cfgFor(input int interval);
    return 32'(interval & 12'hFFF) << 9;
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: scrubRdEn actual %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // reset with scrubbing enabled and no blockers, release at a falling edge
  task automatic startRun(input logic [31:0] cfg);
    @(negedge clk);
    rstN = 1'b0;
    cfgWord = cfg; scrubEn = 1'b1; selfRefresh = 1'b0;
    scrubWrValid = 1'b0; scrubWrPending = 1'b0; scrubRdAck = 1'b0;
    cycles(2);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    startRun(cfgFor(1));
    rstN = 1'b0;
    #1 check(scrubRdEn, 1'b0, "R1 during reset");
    rstN = 1'b1;
    #1 check(scrubRdEn, 1'b0, "R1 after release");
  endtask

  task automatic testThreshold();
    startRun(cfgFor(5));
    cycles(4);
    check(scrubRdEn, 1'b0, "R2 before interval");
    cycles(1);
    check(scrubRdEn, 1'b1, "R2 at interval");
    cycles(7);
    check(scrubRdEn, 1'b1, "R3 past interval");
  endtask

  task automatic testAckClear();
    startRun(cfgFor(5));
    cycles(5);
    scrubRdAck = 1'b1;
    cycles(1);
    scrubRdAck = 1'b0;
    check(scrubRdEn, 1'b0, "R4 cleared by ack");
    cycles(4);
    check(scrubRdEn, 1'b0, "R4 restarted from zero");
    cycles(1);
    check(scrubRdEn, 1'b1, "R4 next interval");
  endtask

  task automatic testIdleAck();
    startRun(cfgFor(5));
    scrubRdAck = 1'b1;
    cycles(3);
    scrubRdAck = 1'b0;
    cycles(2);
    check(scrubRdEn, 1'b1, "R5 idle ack ignored");
  endtask

  task automatic testDisable();
    startRun(cfgFor(5));
    cycles(3);
    scrubEn = 1'b0;
    cycles(10);
    check(scrubRdEn, 1'b0, "R6 disabled");
    scrubEn = 1'b1;
    cycles(1);
    check(scrubRdEn, 1'b0, "R6 counter held");
    cycles(1);
    check(scrubRdEn, 1'b1, "R6 resumes");
    scrubEn = 1'b0;
    #1 check(scrubRdEn, 1'b0, "R6 request dropped");
    scrubEn = 1'b1;
  endtask

  task automatic testSelfRefresh();
    startRun(cfgFor(5));
    cycles(3);
    selfRefresh = 1'b1;
    cycles(10);
    check(scrubRdEn, 1'b0, "R7 self-refresh");
    selfRefresh = 1'b0;
    cycles(1);
    check(scrubRdEn, 1'b0, "R7 counter held");
    cycles(1);
    check(scrubRdEn, 1'b1, "R7 resumes");
    selfRefresh = 1'b1;
    #1 check(scrubRdEn, 1'b0, "R7 request dropped");
    selfRefresh = 1'b0;
  endtask

  task automatic testWriteBlock();
    startRun(cfgFor(3));
    scrubWrValid = 1'b1;
    cycles(6);
    check(scrubRdEn, 1'b0, "R8 write valid blocks");
    scrubWrValid = 1'b0;
    #1 check(scrubRdEn, 1'b1, "R8 released");
    scrubWrPending = 1'b1;
    #1 check(scrubRdEn, 1'b0, "R9 write pending blocks");
    cycles(4);
    check(scrubRdEn, 1'b0, "R9 still pending");
    scrubWrPending = 1'b0;
    #1 check(scrubRdEn, 1'b1, "R9 released");
  endtask

  task automatic testSaturate();
    startRun(cfgFor(4095));
    cycles(4094);
    check(scrubRdEn, 1'b0, "R10 below max");
    cycles(1);
    check(scrubRdEn, 1'b1, "R10 reached max");
    cycles(20);
    check(scrubRdEn, 1'b1, "R10 no wrap");
  endtask

  task automatic testField();
    startRun(~(32'hFFF << 9) | (32'd3 << 9));
    cycles(2);
    check(scrubRdEn, 1'b0, "R11 outside bits ignored (early)");
    cycles(1);
    check(scrubRdEn, 1'b1, "R11 outside bits ignored (at 3)");
  endtask

  task automatic testZero();
    startRun(cfgFor(0));
    #1 check(scrubRdEn, 1'b1, "R12 zero interval");
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; cfgWord = '0; scrubEn = 1'b0; selfRefresh = 1'b0;
    scrubWrValid = 1'b0; scrubWrPending = 1'b0; scrubRdAck = 1'b0;
    testReset();
    testThreshold();
    testAckClear();
    testIdleAck();
    testDisable();
    testSelfRefresh();
    testWriteBlock();
    testSaturate();
    testField();
    testZero();
    finishRun();
  end
endmodule